// File: doc/BRIEF.md
# Two-Axis Position Snapshot Byte Reader

This block sits between two free-running position counters and an 8-bit data bus. Each axis has its own 32-bit holding latch. While no read is in progress, a latch copies its axis's counter on every falling clock edge. A host reads a position over the narrow bus as four bytes. It picks the axis with a single select input and picks the byte with two select lines. The two select lines use a non-binary code.

Inhibit logic runs on the falling clock edge. When it first sees the active-low output enable asserted for an axis, it freezes that axis's latch. Every byte of the read then comes from one coherent snapshot, even if the counter keeps moving. The freeze lifts only after the host has selected the least significant byte and then deasserted output enable. The next read therefore starts from a fresh snapshot.

Each axis has its own active-low asynchronous reset. It clears that axis's latch and its inhibit state and leaves the other axis alone. The bus itself is modelled as a data output plus a drive-enable flag for the tri-state buffers.

Top module: `pos_byte_reader`

## Requirements
- R1: `drive_en_o` is the inverse of `oe_ni`. While `oe_ni` is high, `data_o` reads 0.
- R2: The byte on `data_o` is chosen by `{sel1_i, sel2_i}`:
  - 2'b01 selects bits 31:24.
  - 2'b11 selects bits 23:16.
  - 2'b00 selects bits 15:8.
  - 2'b10 selects bits 7:0.
- R3: `axis_sel_i` = 0 reads the axis 0 latch, and `axis_sel_i` = 1 reads the axis 1 latch.
- R4: While an axis is not inhibited, its latch takes that axis's counter value at every falling clock edge.
- R5: The inhibit flag of an axis is set at the first falling edge where `oe_ni` is sampled low with that axis selected. That edge still loads the latch, and the latch then holds while the counter changes.
- R6: An inhibited axis is released at the first falling edge where `oe_ni` is sampled high, provided that an earlier falling edge of the read sampled `oe_ni` low with the least-significant-byte code 2'b10. The latch holds on that edge and loads again on the edge after it.
- R7: A read that never selects the least significant byte does not release the freeze, even if `oe_ni` goes high in between.
- R8: A low on `rst_ni[k]` clears latch k and the inhibit state of axis k at once. The other axis keeps its latch and its inhibit state.
- R9: A read of one axis does not freeze the other axis, which keeps tracking its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; latch and inhibit state update on its falling edge |
| rst_ni | input | 2 | Per-axis active-low asynchronous reset, bit k for axis k |
| cnt_i | input | 64 | Live counter values, axis k in bits 32k+31:32k |
| oe_ni | input | 1 | Active-low output enable |
| sel1_i | input | 1 | Byte select line 1 |
| sel2_i | input | 1 | Byte select line 2 |
| axis_sel_i | input | 1 | Axis select (0 = axis 0, 1 = axis 1) |
| data_o | output | 8 | Selected latch byte, 0 when not driven |
| drive_en_o | output | 1 | Enable for the external tri-state bus buffers |

## Verification
A full four-byte read in the order MSB, 2nd, 3rd, LSB is run while the counter changes after the first byte. Returning the old bytes shows that the freeze holds and that the select code maps each byte correctly. A read that stops after the MSB and then retries shows that leaving out the LSB select does not release the freeze, whereas a complete read followed by `oe_ni` high does release it. Interleaving reads of the two axes, and pulsing one axis's reset in the middle of a read, separates per-axis inhibit state from shared state. A per-clock reference model also follows counter values that change every cycle while no read is in progress.

// File: rtl/pos_rd_pkg.sv
package pos_rd_pkg;
  // Byte select code, packed as {sel1, sel2}
  typedef enum logic [1:0] {
    BSEL_3RD = 2'b00,
    BSEL_MSB = 2'b01,
    BSEL_LSB = 2'b10,
    BSEL_2ND = 2'b11
  } bsel_e;

  function automatic logic [1:0] bsel_to_idx(input bsel_e s);
    case (s)
      BSEL_MSB: return 2'd3;
      BSEL_2ND: return 2'd2;
      BSEL_3RD: return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pos_rd_inhibit.sv
module pos_rd_inhibit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic mine_i,
  input  logic lsb_sel_i,
  output logic inhibit_o
);
  logic inh_q, lsb_seen_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q      <= 1'b0;
      lsb_seen_q <= 1'b0;
    end else if (!inh_q) begin
      inh_q      <= !oe_ni && mine_i;
      lsb_seen_q <= 1'b0;
    end else if (oe_ni && lsb_seen_q) begin
      inh_q      <= 1'b0;
      lsb_seen_q <= 1'b0;
    end else if (!oe_ni && mine_i && lsb_sel_i) begin
      lsb_seen_q <= 1'b1;
    end
  end

  assign inhibit_o = inh_q;

  a_r5_sets_on_read: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!oe_ni && mine_i) |=> inhibit_o);

  a_r6_releases: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (inhibit_o && lsb_seen_q && oe_ni) |=> !inhibit_o);

  a_r7_holds_without_lsb: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (inhibit_o && !lsb_seen_q && !(!oe_ni && mine_i && lsb_sel_i)) |=> inhibit_o);
endmodule

// File: rtl/pos_rd_latch.sv
module pos_rd_latch #(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [POS_W-1:0] cnt_i,
  output logic [POS_W-1:0] q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= cnt_i;
  end

  a_r5_frozen: assert property (@(negedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(q_o));

  a_r4_tracks: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (q_o == $past(cnt_i)));
endmodule

// File: rtl/pos_rd_mux.sv
module pos_rd_mux
  import pos_rd_pkg::*;
#(
  parameter int unsigned POS_W    = 32,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned NUM_AXES = 2,
  localparam int unsigned AXIS_W  = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1
) (
  input  logic [NUM_AXES-1:0][POS_W-1:0] lat_i,
  input  logic [AXIS_W-1:0]              axis_i,
  input  bsel_e                          sel_i,
  input  logic                           oe_ni,
  output logic [BYTE_W-1:0]              data_o,
  output logic                           drive_en_o
);
  logic [POS_W-1:0]  word;
  logic [1:0]        idx;

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_AXES; k++)
      if (axis_i == AXIS_W'(k)) word = lat_i[k];
  end

  assign idx        = bsel_to_idx(sel_i);
  assign drive_en_o = !oe_ni;
  assign data_o     = drive_en_o ? word[idx*BYTE_W +: BYTE_W] : '0;
endmodule

// File: rtl/pos_byte_reader.sv
module pos_byte_reader
  import pos_rd_pkg::*;
#(
  parameter int unsigned POS_W    = 32,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned NUM_AXES = 2,
  localparam int unsigned AXIS_W  = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1
) (
  input  logic                           clk_i,
  input  logic [NUM_AXES-1:0]            rst_ni,
  input  logic [NUM_AXES-1:0][POS_W-1:0] cnt_i,
  input  logic                           oe_ni,
  input  logic                           sel1_i,
  input  logic                           sel2_i,
  input  logic [AXIS_W-1:0]              axis_sel_i,
  output logic [BYTE_W-1:0]              data_o,
  output logic                           drive_en_o
);
  bsel_e                          bsel;
  logic [NUM_AXES-1:0][POS_W-1:0] lat;
  logic [NUM_AXES-1:0]            inhibit;

  assign bsel = bsel_e'({sel1_i, sel2_i});

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    pos_rd_inhibit u_inh (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni[k]),
      .oe_ni     (oe_ni),
      .mine_i    (axis_sel_i == AXIS_W'(k)),
      .lsb_sel_i (bsel == BSEL_LSB),
      .inhibit_o (inhibit[k])
    );

    pos_rd_latch #(.POS_W(POS_W)) u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni[k]),
      .hold_i (inhibit[k]),
      .cnt_i  (cnt_i[k]),
      .q_o    (lat[k])
    );
  end

  pos_rd_mux #(.POS_W(POS_W), .BYTE_W(BYTE_W), .NUM_AXES(NUM_AXES)) u_mux (
    .lat_i      (lat),
    .axis_i     (axis_sel_i),
    .sel_i      (bsel),
    .oe_ni      (oe_ni),
    .data_o     (data_o),
    .drive_en_o (drive_en_o)
  );

  a_r1_idle_bus: assert property (@(posedge clk_i) disable iff (!(&rst_ni))
    oe_ni |-> (data_o == '0 && !drive_en_o));
endmodule

// File: tb/pos_byte_reader_bench.sv
module pos_byte_reader_bench;
  localparam int unsigned T = 8;

  logic              clk = 1'b0;
  logic [1:0]        rst_n = 2'b00;
  logic [1:0][31:0]  cnt = '0;
  logic              oe_n = 1'b1, s1 = 1'b0, s2 = 1'b0, ax = 1'b0;
  logic [7:0]        data;
  logic              den;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int unsigned m_lat[2];
  bit          m_inh[2];
  bit          m_lsb[2];

  always #(T/2) clk = ~clk;

  pos_byte_reader u_pos_byte_reader (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .oe_ni(oe_n),
    .sel1_i(s1), .sel2_i(s2), .axis_sel_i(ax),
    .data_o(data), .drive_en_o(den));

  function automatic int unsigned exp_byte();
    int unsigned w;
    int sh;
    if (oe_n) return 0;
    w = m_lat[ax];
    case ({s1, s2})
      2'b01: sh = 24;
      2'b11: sh = 16;
      2'b00: sh = 8;
      default: sh = 0;
    endcase
    return (w >> sh) & 8'hFF;
  endfunction

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n[k]) begin
        m_lat[k] = 0; m_inh[k] = 0; m_lsb[k] = 0;
      end else if (!m_inh[k]) begin
        m_lat[k] = cnt[k];
        m_inh[k] = !oe_n && (ax == k[0]);
        m_lsb[k] = 0;
      end else if (oe_n && m_lsb[k]) begin
        m_inh[k] = 0; m_lsb[k] = 0;
      end else if (!oe_n && ax == k[0] && {s1, s2} == 2'b10) begin
        m_lsb[k] = 1;
      end
    end
  end

  // per-clock comparison against the model (R1 R2 R3 R4)
  always @(posedge clk) begin
    if (!done && $time > 0) begin
      checks++;
      if (data !== 8'(exp_byte()) || den !== !oe_n) begin
        fails++;
        $display("FAIL R1/R2/R3/R4 model t=%0t data=%h en=%b exp data=%h en=%b",
                 $time, data, den, 8'(exp_byte()), !oe_n);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp_d, input logic exp_en);
    checks++;
    if (data !== exp_d || den !== exp_en) begin
      fails++;
      $display("FAIL %s data=%h en=%b exp data=%h en=%b", req, data, den, exp_d, exp_en);
    end
  endtask

  // drive after posedge, settle past negedge
  task automatic cyc(input logic o, input logic [1:0] sel, input logic a);
    @(posedge clk); #1;
    oe_n = o; {s1, s2} = sel; ax = a;
    @(negedge clk); #1;
  endtask

  localparam logic [1:0] MSB = 2'b01, B2 = 2'b11, B3 = 2'b00, LSB = 2'b10;

  initial begin
    #(T*200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cnt[0] = 32'h11223344; cnt[1] = 32'hAABBCCDD;
    cyc(1'b0, MSB, 1'b0);
    chk("R8 reset clears latch", 8'h00, 1'b1);
    cyc(1'b1, MSB, 1'b0);
    chk("R1 idle bus", 8'h00, 1'b0);
    @(posedge clk); #1; rst_n = 2'b11;
    repeat (3) cyc(1'b1, MSB, 1'b0);

    // R4 tracking with moving counter, no read
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; cnt[0] = cnt[0] + 32'h01010101; cnt[1] = cnt[1] - 32'd7;
    end
    @(posedge clk); #1; cnt[0] = 32'h11223344; cnt[1] = 32'hAABBCCDD;
    cyc(1'b1, MSB, 1'b0);

    // full read of axis 0 with counter moving (R2 R5)
    cyc(1'b0, MSB, 1'b0); chk("R2 msb", 8'h11, 1'b1);
    cnt[0] = 32'h55667788;
    cyc(1'b0, B2, 1'b0);  chk("R5 frozen 2nd", 8'h22, 1'b1);
    cyc(1'b0, B3, 1'b0);  chk("R2 3rd", 8'h33, 1'b1);
    cyc(1'b0, LSB, 1'b0); chk("R2 lsb", 8'h44, 1'b1);
    cyc(1'b1, LSB, 1'b0); chk("R1 released bus", 8'h00, 1'b0);
    cyc(1'b0, MSB, 1'b0); chk("R6 fresh snapshot", 8'h55, 1'b1);

    // partial read: no LSB, must stay frozen (R7)
    cnt[0] = 32'h99AABBCC;
    cyc(1'b1, MSB, 1'b0);
    cyc(1'b1, MSB, 1'b0);
    cyc(1'b0, LSB, 1'b0); chk("R7 still frozen", 8'h88, 1'b1);
    cyc(1'b1, LSB, 1'b0);
    cyc(1'b0, B2, 1'b0);  chk("R6 release after lsb", 8'hAA, 1'b1);
    cyc(1'b0, LSB, 1'b0);
    cyc(1'b1, LSB, 1'b0);

    // axis 1 read leaves axis 0 tracking (R3 R9)
    cyc(1'b0, MSB, 1'b1); chk("R3 axis1 msb", 8'hAA, 1'b1);
    cnt[0] = 32'h0F1E2D3C; cnt[1] = 32'h12345678;
    cyc(1'b0, LSB, 1'b1); chk("R3 axis1 lsb frozen", 8'hDD, 1'b1);
    cyc(1'b0, MSB, 1'b0); chk("R9 axis0 tracked", 8'h0F, 1'b1);

    // both frozen; reset axis 0 only (R8)
    cnt[0] = 32'h01020304;
    @(posedge clk); #1; rst_n = 2'b10; #1;
    chk("R8 axis0 cleared async", 8'h00, 1'b1);
    @(posedge clk); #1; rst_n = 2'b11;
    cyc(1'b0, B2, 1'b1);  chk("R8 axis1 kept", 8'hBB, 1'b1);
    cyc(1'b0, B3, 1'b0);  chk("R8 axis0 fresh", 8'h03, 1'b1);
    cnt[0] = 32'hFFFFFFFF;
    cyc(1'b0, LSB, 1'b0); chk("R8 axis0 refrozen", 8'h04, 1'b1);
    cyc(1'b1, LSB, 1'b0);
    repeat (3) cyc(1'b1, B3, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule